// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable power island up and down in hardware. An on request closes the island's power switch with a low inrush current limit. If the supply does not report good within a fixed window, the block raises the limit one step and waits again. Once the supply is good it drops the electrical clamps, starts memory repair and waits for it to finish. Only after that does it drop the functional clamps. An off request runs the reverse order. Any timeout during power-up undoes the steps already taken, in reverse order, and ends with an error pulse.

The surrounding logic gives a one-cycle request and waits for a one-cycle done or error pulse. The power-good and repair-done inputs come from the analog side. They pass through an optional synchroniser chain. A packed control word shows the live state of the island at fixed bit positions, for a neighbouring block to decode.

Top module: `pwr_dom_seq`

## Requirements
- R1: During and after reset every control output, `busy_o`, `done_o`, `err_o`, `inrush_o` and `ctrl_o` are zero.
- R2: An on request accepted while the switch is open closes the switch with inrush code 0 on the next clock, and `busy_o` is high from that cycle.
- R3: An on request that arrives while the switch is already closed gives a done pulse one cycle later and changes no control output.
- R4: Power-up order is switch closed, then electrical isolation released, then repair requested, then (after repair done) functional isolation released, then done. An isolation output never changes in the same cycle as the switch enable.
- R5: Inrush codes 0, 1, 2 and 3 are tried in rising order, each for a window of `PGOOD_WAIT` cycles with the switch held closed. Stepping stops at the first code that gives power-good, and `inrush_o` keeps that code.
- R6: If power-good has not appeared by the end of the last code's window, the switch opens, the inrush code returns to 0, isolation stays asserted and an error pulse follows.
- R7: If repair done has not appeared within `REPAIR_WAIT` cycles, electrical isolation is reasserted and the repair request dropped. One cycle later the switch opens and the code returns to 0. An error pulse follows.
- R8: Power-down asserts functional isolation, then electrical isolation on the next cycle, then opens the switch and drops the repair request on the cycle after. It then gives a done pulse and keeps the inrush code unchanged.
- R9: On and off requests that arrive while `busy_o` is high are ignored. Each accepted request yields exactly one completion pulse, and `busy_o` stays high until that pulse.
- R10: `ctrl_o` bit 0 is the switch enable, bit 1 the synchronised power-good, bit 2 electrical-isolation release, bit 3 repair request, bit 4 the synchronised repair done, bit 5 functional-isolation release, bits 14:13 the inrush code. All other bits are zero.
- R11: If on and off requests arrive together while idle, the on request is taken and the off request is dropped.
- R12: `done_o` and `err_o` are single-cycle pulses and are never high together; `inrush_o` changes only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Power-up request, one cycle |
| off_req_i | input | 1 | Power-down request, one cycle |
| pgood_i | input | 1 | Supply-good indication from the switch |
| repair_done_i | input | 1 | Memory repair finished |
| sw_en_o | output | 1 | Power switch enable |
| inrush_o | output | 2 | Inrush current limit code |
| elec_iso_rel_o | output | 1 | Electrical isolation released |
| repair_req_o | output | 1 | Memory repair request |
| func_iso_rel_o | output | 1 | Functional isolation released |
| ctrl_o | output | 15 | Packed control and status word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one cycle |
| err_o | output | 1 | Sequence failed and was unwound, one cycle |

## Verification
The bench models the supply so that power-good appears only at or above a chosen inrush code. It drives cases where the first, the third and no code succeed. A design that stepped through every code, or kept its last code, would report the wrong code on completion or show extra code changes. A design that did not clear the code on failure would also be caught by these cases. The bench records every edge of the control outputs and compares the full order for power-up, power-down and both rollback paths. A swapped or merged step shows up as a different edge order. Requests fired into a busy sequence and a simultaneous on/off pair test the idle arbitration. A design that accepted them would emit an extra pulse or run power-down.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   // Packed control word layout (decoded by a neighbouring block)
   localparam int CTRL_W      = 15;
   localparam int BIT_SW      = 0;
   localparam int BIT_PGOOD   = 1;
   localparam int BIT_EISO    = 2;
   localparam int BIT_REPREQ  = 3;
   localparam int BIT_REPDONE = 4;
   localparam int BIT_FISO    = 5;
   localparam int INRUSH_LSB  = 13;
   localparam int INRUSH_W    = 2;

   typedef logic [INRUSH_W-1:0] inrush_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PU_WAIT,
      ST_REP_REQ,
      ST_REP_WAIT,
      ST_RB_SW,
      ST_PD_EISO,
      ST_PD_SW,
      ST_OK,
      ST_FAIL
   } seq_state_e;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= STAGES'({chain_q, d});
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int TMR_W      = 8,
   parameter int PGOOD_WAIT = 150,
   parameter int REPAIR_WAIT = 50,
   parameter int LAST_CODE  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_req,
   input  logic             off_req,
   input  logic             pgood_s,
   input  logic             rdone_s,
   input  logic             tmr_exp,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val,
   output logic             sw_en,
   output inrush_t          inrush,
   output logic             eiso_rel,
   output logic             rep_req,
   output logic             fiso_rel,
   output logic             busy,
   output logic             done,
   output logic             err
);

   localparam logic [TMR_W-1:0] PG_LOAD = TMR_W'(PGOOD_WAIT);
   localparam logic [TMR_W-1:0] RD_LOAD = TMR_W'(REPAIR_WAIT);
   localparam inrush_t          CODE_MAX = inrush_t'(LAST_CODE);

   seq_state_e state_q;
   logic       at_last;

   assign at_last = (inrush == CODE_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sw_en    <= 1'b0;
         inrush   <= '0;
         eiso_rel <= 1'b0;
         rep_req  <= 1'b0;
         fiso_rel <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (on_req) begin
                  if (sw_en) begin
                     state_q <= ST_OK;
                  end else begin
                     sw_en   <= 1'b1;
                     inrush  <= '0;
                     state_q <= ST_PU_WAIT;
                  end
               end else if (off_req) begin
                  fiso_rel <= 1'b0;
                  state_q  <= ST_PD_EISO;
               end
            end
            ST_PU_WAIT: begin
               if (pgood_s) begin
                  eiso_rel <= 1'b1;
                  state_q  <= ST_REP_REQ;
               end else if (tmr_exp) begin
                  if (at_last) begin
                     sw_en   <= 1'b0;
                     inrush  <= '0;
                     state_q <= ST_FAIL;
                  end else begin
                     inrush <= inrush + inrush_t'(1);
                  end
               end
            end
            ST_REP_REQ: begin
               rep_req <= 1'b1;
               state_q <= ST_REP_WAIT;
            end
            ST_REP_WAIT: begin
               if (rdone_s) begin
                  fiso_rel <= 1'b1;
                  state_q  <= ST_OK;
               end else if (tmr_exp) begin
                  eiso_rel <= 1'b0;
                  rep_req  <= 1'b0;
                  state_q  <= ST_RB_SW;
               end
            end
            ST_RB_SW: begin
               sw_en   <= 1'b0;
               inrush  <= '0;
               state_q <= ST_FAIL;
            end
            ST_PD_EISO: begin
               eiso_rel <= 1'b0;
               state_q  <= ST_PD_SW;
            end
            ST_PD_SW: begin
               sw_en   <= 1'b0;
               rep_req <= 1'b0;
               state_q <= ST_OK;
            end
            ST_OK, ST_FAIL: state_q <= ST_IDLE;
            default:        state_q <= ST_IDLE;
         endcase
      end
   end

   // timer reload points: entry to a wait and each new inrush step
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = PG_LOAD;
      case (state_q)
         ST_IDLE:     tmr_load = on_req && !sw_en;
         ST_PU_WAIT:  tmr_load = !pgood_s && tmr_exp && !at_last;
         ST_REP_REQ: begin
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
         end
         default:     tmr_load = 1'b0;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_OK);
   assign err  = (state_q == ST_FAIL);

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
   import pwr_seq_pkg::*;
#(
   parameter int PGOOD_WAIT  = 150,
   parameter int REPAIR_WAIT = 50,
   parameter int LAST_CODE   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                on_req_i,
   input  logic                off_req_i,
   input  logic                pgood_i,
   input  logic                repair_done_i,
   output logic                sw_en_o,
   output logic [INRUSH_W-1:0] inrush_o,
   output logic                elec_iso_rel_o,
   output logic                repair_req_o,
   output logic                func_iso_rel_o,
   output logic [CTRL_W-1:0]   ctrl_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o
);

   localparam int MAX_WAIT = (PGOOD_WAIT > REPAIR_WAIT) ? PGOOD_WAIT : REPAIR_WAIT;
   localparam int TMR_W    = $clog2(MAX_WAIT + 1);

   generate
      if (PGOOD_WAIT < 1) begin : g_bad_pg
         $error("PGOOD_WAIT must be at least 1");
      end
      if (REPAIR_WAIT < 1) begin : g_bad_rd
         $error("REPAIR_WAIT must be at least 1");
      end
      if (LAST_CODE < 0 || LAST_CODE >= (1 << INRUSH_W)) begin : g_bad_code
         $error("LAST_CODE outside the inrush code range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic             pgood_s, rdone_s;
   logic             tmr_load, tmr_exp;
   logic [TMR_W-1:0] tmr_val;
   inrush_t          inrush;

   pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_sync_pg (
      .clk(clk), .rst_n(rst_n), .d(pgood_i), .q(pgood_s)
   );

   pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (
      .clk(clk), .rst_n(rst_n), .d(repair_done_i), .q(rdone_s)
   );

   pwr_seq_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_exp)
   );

   pwr_seq_fsm #(
      .TMR_W(TMR_W), .PGOOD_WAIT(PGOOD_WAIT),
      .REPAIR_WAIT(REPAIR_WAIT), .LAST_CODE(LAST_CODE)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .on_req(on_req_i), .off_req(off_req_i),
      .pgood_s(pgood_s), .rdone_s(rdone_s), .tmr_exp(tmr_exp),
      .tmr_load(tmr_load), .tmr_val(tmr_val),
      .sw_en(sw_en_o), .inrush(inrush),
      .eiso_rel(elec_iso_rel_o), .rep_req(repair_req_o),
      .fiso_rel(func_iso_rel_o),
      .busy(busy_o), .done(done_o), .err(err_o)
   );

   assign inrush_o = inrush;

   always_comb begin
      ctrl_o              = '0;
      ctrl_o[BIT_SW]      = sw_en_o;
      ctrl_o[BIT_PGOOD]   = pgood_s;
      ctrl_o[BIT_EISO]    = elec_iso_rel_o;
      ctrl_o[BIT_REPREQ]  = repair_req_o;
      ctrl_o[BIT_REPDONE] = rdone_s;
      ctrl_o[BIT_FISO]    = func_iso_rel_o;
      ctrl_o[INRUSH_LSB +: INRUSH_W] = inrush;
   end

endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk
   import pwr_seq_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                sw_en_o,
   input logic [INRUSH_W-1:0] inrush_o,
   input logic                elec_iso_rel_o,
   input logic                repair_req_o,
   input logic                func_iso_rel_o,
   input logic                busy_o,
   input logic                done_o,
   input logic                err_o
);

   // R4
   iso_steady_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_o != $past(sw_en_o)) |->
         (elec_iso_rel_o == $past(elec_iso_rel_o) && func_iso_rel_o == $past(func_iso_rel_o)));

   // R4
   fiso_after_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(func_iso_rel_o) |-> (elec_iso_rel_o && repair_req_o && sw_en_o));

   // R8
   switch_opens_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_en_o) |-> (!elec_iso_rel_o && !func_iso_rel_o));

   // R6
   err_switch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!sw_en_o && inrush_o == '0 && !elec_iso_rel_o && !func_iso_rel_o));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && !err_o) |=> busy_o);

   // R12
   pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   // R12
   code_moves_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inrush_o != $past(inrush_o)) |-> busy_o);

endmodule

bind pwr_dom_seq pwr_dom_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sw_en_o(sw_en_o), .inrush_o(inrush_o),
   .elec_iso_rel_o(elec_iso_rel_o), .repair_req_o(repair_req_o),
   .func_iso_rel_o(func_iso_rel_o), .busy_o(busy_o),
   .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_pwr_dom_seq.sv
module tb_pwr_dom_seq;

   localparam int PGW = 20;
   localparam int RDW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        on_req_i = 1'b0;
   logic        off_req_i = 1'b0;
   logic        pgood_i, repair_done_i;
   logic        sw_en_o, elec_iso_rel_o, repair_req_o, func_iso_rel_o;
   logic [1:0]  inrush_o;
   logic [14:0] ctrl_o;
   logic        busy_o, done_o, err_o;

   always #10 clk = ~clk;

   pwr_dom_seq #(.PGOOD_WAIT(PGW), .REPAIR_WAIT(RDW)) dut (
      .clk(clk), .rst_n(rst_n), .on_req_i(on_req_i), .off_req_i(off_req_i),
      .pgood_i(pgood_i), .repair_done_i(repair_done_i),
      .sw_en_o(sw_en_o), .inrush_o(inrush_o),
      .elec_iso_rel_o(elec_iso_rel_o), .repair_req_o(repair_req_o),
      .func_iso_rel_o(func_iso_rel_o), .ctrl_o(ctrl_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // supply and repair models
   int pg_min = 0;
   int pg_dly = 4;
   int rd_dly = 3;
   int pg_cnt = 0;
   int rd_cnt = 0;

   always @(posedge clk) begin
      if (!sw_en_o || int'(inrush_o) < pg_min) pg_cnt <= 0;
      else if (pg_cnt < 1000000)               pg_cnt <= pg_cnt + 1;
      if (!repair_req_o)                       rd_cnt <= 0;
      else if (rd_cnt < 1000000)               rd_cnt <= rd_cnt + 1;
   end

   assign pgood_i       = sw_en_o && (int'(inrush_o) >= pg_min) && (pg_cnt >= pg_dly);
   assign repair_done_i = repair_req_o && (rd_cnt >= rd_dly);

   // scoreboard
   typedef struct packed {
      logic       err;
      logic [1:0] code;
   } res_t;

   res_t  exp_q[$];
   string tag_q[$];

   always @(negedge clk) begin
      res_t  e;
      string t;
      if (rst_n && (done_o || err_o)) begin
         if (exp_q.size() == 0) begin
            chk("R9", "unexpected completion pulse", 1, 0);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "outcome {err,code}", longint'({err_o, inrush_o}), longint'(e));
         end
         chk("R12", "done and err together", longint'(done_o && err_o), 0);
      end
   end

   // edge logger: 1 sw up, 2 eiso up, 3 rep up, 4 fiso up, 5 fiso down, 6 eiso down, 7 rep down, 8 sw down
   int   ev_q[$];
   int   cd_q[$];
   logic p_sw, p_e, p_r, p_f;
   logic [1:0] p_cd;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_f && !func_iso_rel_o)  ev_q.push_back(5);
         if (p_e && !elec_iso_rel_o)  ev_q.push_back(6);
         if (p_r && !repair_req_o)    ev_q.push_back(7);
         if (p_sw && !sw_en_o)        ev_q.push_back(8);
         if (!p_sw && sw_en_o)        ev_q.push_back(1);
         if (!p_e && elec_iso_rel_o)  ev_q.push_back(2);
         if (!p_r && repair_req_o)    ev_q.push_back(3);
         if (!p_f && func_iso_rel_o)  ev_q.push_back(4);
         if (p_cd != inrush_o)        cd_q.push_back(int'(inrush_o) + 1);
      end
      p_sw = sw_en_o;
      p_e  = elec_iso_rel_o;
      p_r  = repair_req_o;
      p_f  = func_iso_rel_o;
      p_cd = inrush_o;
   end

   int ev_base = 0;
   int cd_base = 0;

   function automatic longint ev_sig();
      longint s = 0;
      for (int i = ev_base; i < ev_q.size(); i++) s = (s << 4) | longint'(ev_q[i]);
      return s;
   endfunction

   function automatic longint cd_sig();
      longint s = 0;
      for (int i = cd_base; i < cd_q.size(); i++) s = (s << 4) | longint'(cd_q[i]);
      return s;
   endfunction

   task automatic wait_idle(input string tag);
      int n = 0;
      @(negedge clk);
      while (busy_o && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, "sequence finished", longint'(busy_o), 0);
   endtask

   task automatic push_exp(input logic err, input logic [1:0] code, input string tag);
      res_t r;
      r.err  = err;
      r.code = code;
      exp_q.push_back(r);
      tag_q.push_back(tag);
      ev_base = ev_q.size();
      cd_base = cd_q.size();
   endtask

   task automatic do_op(input bit on, input bit off, input logic err,
                        input logic [1:0] code, input string tag);
      push_exp(err, code, tag);
      @(negedge clk);
      on_req_i  = on;
      off_req_i = off;
      @(negedge clk);
      on_req_i  = 1'b0;
      off_req_i = 1'b0;
      chk("R2", "busy after accepted request", longint'(busy_o), 1);
      wait_idle(tag);
      chk(tag, "scoreboard drained", exp_q.size(), 0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", "outputs in reset",
          longint'({sw_en_o, elec_iso_rel_o, repair_req_o, func_iso_rel_o,
                    busy_o, done_o, err_o, inrush_o}), 0);
      chk("R1", "ctrl word in reset", longint'(ctrl_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after release",
          longint'({sw_en_o, busy_o, done_o, err_o, inrush_o}), 0);

      // R4 plain power-up, first code succeeds
      pg_min = 0; pg_dly = 4; rd_dly = 3;
      do_op(1'b1, 1'b0, 1'b0, 2'd0, "R4");
      chk("R4", "power-up edge order", ev_sig(), 64'h1234);
      chk("R5", "no code stepping when code 0 succeeds", cd_sig(), 0);

      // R3 on while already on
      do_op(1'b1, 1'b0, 1'b0, 2'd0, "R3");
      chk("R3", "no output edges", ev_sig(), 0);

      // R8 power-down
      do_op(1'b0, 1'b1, 1'b0, 2'd0, "R8");
      chk("R8", "power-down edge order", ev_sig(), 64'h5678);

      // R5 third code succeeds
      pg_min = 2;
      do_op(1'b1, 1'b0, 1'b0, 2'd2, "R5");
      chk("R5", "edge order with stepping", ev_sig(), 64'h1234);
      chk("R5", "code steps 0->1->2 then stop", cd_sig(), 64'h23);

      // R8 power-down keeps the code
      do_op(1'b0, 1'b1, 1'b0, 2'd2, "R8");
      chk("R8", "power-down edge order", ev_sig(), 64'h5678);

      // R6 no code succeeds
      pg_min = 4;
      do_op(1'b1, 1'b0, 1'b1, 2'd0, "R6");
      chk("R6", "switch closed then opened only", ev_sig(), 64'h18);
      chk("R6", "codes 0,1,2,3 then back to 0", cd_sig(), 64'h12341);

      // R7 repair times out
      pg_min = 0; rd_dly = 1000000;
      do_op(1'b1, 1'b0, 1'b1, 2'd0, "R7");
      chk("R7", "rollback edge order", ev_sig(), 64'h123678);

      // R9 requests while busy are ignored
      pg_min = 1; rd_dly = 3;
      push_exp(1'b0, 2'd1, "R9");
      @(negedge clk);
      on_req_i = 1'b1;
      @(negedge clk);
      on_req_i = 1'b0;
      repeat (3) @(negedge clk);
      on_req_i  = 1'b1;
      off_req_i = 1'b1;
      @(negedge clk);
      on_req_i  = 1'b0;
      off_req_i = 1'b0;
      wait_idle("R9");
      chk("R9", "scoreboard drained", exp_q.size(), 0);
      chk("R9", "edge order unaffected", ev_sig(), 64'h1234);
      chk("R9", "code stepped to 1 only", cd_sig(), 64'h2);

      // R10 control word when fully on with code 1
      repeat (3) @(negedge clk);
      chk("R10", "ctrl word on", longint'(ctrl_o), 64'h203F);

      // R11 simultaneous requests while idle and on
      do_op(1'b1, 1'b1, 1'b0, 2'd1, "R11");
      chk("R11", "off request dropped", ev_sig(), 0);

      // R10 control word after power-down
      do_op(1'b0, 1'b1, 1'b0, 2'd1, "R8");
      repeat (4) @(negedge clk);
      chk("R10", "ctrl word off", longint'(ctrl_o), 64'h2000);

      summary();
      $finish;
   end

endmodule